// File: doc/BRIEF.md
# Fixed-Point Square-Root Array Engine

This engine computes square roots in place over an array held in an external word-addressed RAM. Each word is a 32-bit unsigned fixed-point value with 8 fractional bits, so 1.0 is 0x100. Address 0 holds the number of operands N, and the operands sit at addresses 1 to N. After a start pulse the engine fetches N. It then reads each operand in turn, refines an estimate of its root with Newton's (Heron's) iteration, and writes the result back over the operand. When the last operand has been written, it raises ready.

Each refinement step divides the operand by the current estimate using a bit-serial divider. The new estimate is the truncated mean of the old estimate and that quotient. The loop stops as soon as the estimate no longer decreases. Operands of 1.0 or less need no iteration and are written back as they are. The engine masters a shared bidirectional data bus, a byte-free word address bus and separate read and write enables. The RAM answers a read combinationally and captures a write on the clock edge.

Top module: `heron_sqrt_engine`

## Requirements
- R1: The reset is synchronous and active high. While it is held, and in the idle cycles after it is released, ready, the read enable and the write enable are all low.
- R2: A start pulse seen in idle makes the engine read address 0 on the next cycle. The read enable stays high with the address unchanged for exactly two cycles (the address phase, then the capture phase) and then drops.
- R3: The word at address 0 is the operand count N, and the operands sit at addresses 1..N. Each address 1..N is written exactly once. Address 0 and address N+1 are never written. With N = 0 nothing is written.
- R4: Words are 32-bit unsigned with 8 fractional bits. An operand at or below 1.0 (0x100), including 0, is written back unchanged.
- R5: For an operand s above 1.0, the seed is s >> 1. Each step forms x' = (x + q) >> 1, truncated to 32 bits. The first step is always taken. After that, the loop ends when x <= x', and x is stored. Two examples: 4.0 (0x400) gives 2.0 (0x200), and 16.0 (0x1000) gives 4.0 (0x400).
- R6: The quotient q of each step is exactly floor((s * 256) / x). It comes from a restoring divider that settles one quotient bit per cycle over 40 cycles, and its remainder is below the divisor.
- R7: Ready rises once the counter reaches zero after the last store. With N = 0, ready is first seen on the fourth falling edge after the start edge. Ready then stays high until reset, and start is ignored both while the engine runs and while ready is high.
- R8: The engine drives the data bus only while the write enable is high. Read and write enables are never high together. Address bits 31..10 are always zero.
- R9: Every write lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a pass over the array when the engine is idle |
| bus_data | inout | 32 | Shared data bus; RAM drives it on reads, engine on writes |
| bus_addr | output | 32 | Word address; only bits 9..0 vary |
| rd_en | output | 1 | Read request to the RAM |
| wr_en | output | 1 | Write request to the RAM |
| ready | output | 1 | Whole array processed |

## Verification
The rising edge that samples start moves the engine into its first read. The count-fetch checks therefore look at the first, second and third falling edges after the start edge, expecting read-high, read-high and read-low. For an empty array, ready is expected low on the third falling edge and high on the fourth.

Result values depend on the iteration count, so there is no fixed latency to check against. The bench waits on ready and then compares every array word with a value it computes from the update rule in R5. It checks the write counts per address, and the words bordering the array, at that same point.

Bus ownership and write width are checked at every falling edge that shows bus activity.

// File: rtl/heron_pkg.sv
package heron_pkg;

    parameter int DATA_W = 32;   // word width
    parameter int FRAC_W = 8;    // fractional bits of the fixed-point format
    parameter int ADDR_W = 32;   // address bus width
    parameter int AIDX_W = 10;   // significant address bits

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CNT_REQ,
        ST_CNT_CAP,
        ST_CNT_TEST,
        ST_OP_REQ,
        ST_OP_CAP,
        ST_RANGE,
        ST_SEED,
        ST_DIV_GO,
        ST_DIV_WAIT,
        ST_REFINE,
        ST_WRITE,
        ST_ADVANCE,
        ST_FINISH
    } heron_state_t;

    // Seed for the iteration: half of the operand.
    function automatic logic [DATA_W-1:0] fx_half(input logic [DATA_W-1:0] v);
        return v >> 1;
    endfunction

endpackage

// File: rtl/heron_div.sv
module heron_div #(
    parameter int DVD_W = 40,
    parameter int DVS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [DVD_W-1:0] quotient
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [DVD_W-1:0] dvd_sh;
    logic [DVS_W-1:0] dvs_r;
    logic [DVS_W-1:0] rem_r;
    logic [CNT_W-1:0] cnt_r;
    logic [DVS_W:0]   trial;
    logic             fits;

    always_comb begin
        trial = {rem_r, dvd_sh[DVD_W-1]};
        fits  = trial >= {1'b0, dvs_r};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            dvd_sh   <= '0;
            dvs_r    <= '0;
            rem_r    <= '0;
            cnt_r    <= '0;
            quotient <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                dvd_sh   <= dividend;
                dvs_r    <= divisor;
                rem_r    <= '0;
                quotient <= '0;
                cnt_r    <= CNT_W'(DVD_W);
                busy     <= 1'b1;
            end else if (busy) begin
                rem_r    <= fits ? DVS_W'(trial - {1'b0, dvs_r}) : DVS_W'(trial);
                quotient <= {quotient[DVD_W-2:0], fits};
                dvd_sh   <= dvd_sh << 1;
                cnt_r    <= cnt_r - CNT_W'(1);
                if (cnt_r == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_DIV_REM_BELOW: assert property (@(posedge clk) disable iff (rst)
        done |-> (rem_r < dvs_r));                                 // R6
    AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                           // R6
    AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);                                          // R6
    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (rst)
        start |-> (divisor != '0));                                // R5

endmodule

// File: rtl/heron_step.sv
module heron_step #(
    parameter int DATA_W = 32,
    parameter int QUO_W  = 40
) (
    input  logic [DATA_W-1:0] x_cur,
    input  logic [QUO_W-1:0]  quo,
    input  logic              first,
    output logic [DATA_W-1:0] x_next,
    output logic              converged
);
    localparam int SUM_W = ((QUO_W > DATA_W) ? QUO_W : DATA_W) + 1;

    always_comb begin
        x_next    = DATA_W'((SUM_W'(x_cur) + SUM_W'(quo)) >> 1);
        converged = !first && (x_cur <= x_next);
    end

endmodule

// File: rtl/heron_sqrt_engine.sv
module heron_sqrt_engine
    import heron_pkg::*;
#(
    parameter int DATA_W = heron_pkg::DATA_W,
    parameter int FRAC_W = heron_pkg::FRAC_W,
    parameter int ADDR_W = heron_pkg::ADDR_W,
    parameter int AIDX_W = heron_pkg::AIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    inout  wire  [DATA_W-1:0] bus_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              rd_en,
    output logic              wr_en,
    output logic              ready
);
    localparam int              DVD_W  = DATA_W + FRAC_W;
    localparam logic [DATA_W-1:0] ONE_FX = DATA_W'(1) << FRAC_W;

    heron_state_t      state;
    logic [DATA_W-1:0] remain_r;
    logic [DATA_W-1:0] s_r;
    logic [DATA_W-1:0] x_r;
    logic [AIDX_W-1:0] idx_r;
    logic [AIDX_W-1:0] addr_idx;
    logic              first_r;

    logic              div_go;
    logic              div_busy;
    logic              div_done;
    logic [DVD_W-1:0]  quot;
    logic [DATA_W-1:0] x_next;
    logic              converged;

    heron_div #(.DVD_W(DVD_W), .DVS_W(DATA_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_go),
        .dividend ({s_r, {FRAC_W{1'b0}}}),
        .divisor  (x_r),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (quot)
    );

    heron_step #(.DATA_W(DATA_W), .QUO_W(DVD_W)) u_step (
        .x_cur     (x_r),
        .quo       (quot),
        .first     (first_r),
        .x_next    (x_next),
        .converged (converged)
    );

    always_comb begin
        rd_en    = state inside {ST_CNT_REQ, ST_CNT_CAP, ST_OP_REQ, ST_OP_CAP};
        wr_en    = (state == ST_WRITE);
        ready    = (state == ST_FINISH);
        div_go   = (state == ST_DIV_GO);
        addr_idx = (state inside {ST_CNT_REQ, ST_CNT_CAP}) ? '0 : idx_r;
        bus_addr = ADDR_W'(addr_idx);
    end

    assign bus_data = wr_en ? x_r : {DATA_W{1'bz}};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            remain_r <= '0;
            s_r      <= '0;
            x_r      <= '0;
            idx_r    <= '0;
            first_r  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE:     if (start) state <= ST_CNT_REQ;
                ST_CNT_REQ:  state <= ST_CNT_CAP;
                ST_CNT_CAP: begin
                    remain_r <= bus_data;
                    idx_r    <= AIDX_W'(1);
                    state    <= ST_CNT_TEST;
                end
                ST_CNT_TEST: state <= (remain_r == '0) ? ST_FINISH : ST_OP_REQ;
                ST_OP_REQ:   state <= ST_OP_CAP;
                ST_OP_CAP: begin
                    s_r   <= bus_data;
                    state <= ST_RANGE;
                end
                ST_RANGE: begin
                    if (s_r > ONE_FX) begin
                        state <= ST_SEED;
                    end else begin
                        x_r   <= s_r;
                        state <= ST_WRITE;
                    end
                end
                ST_SEED: begin
                    x_r     <= fx_half(s_r);
                    first_r <= 1'b1;
                    state   <= ST_DIV_GO;
                end
                ST_DIV_GO:   state <= ST_DIV_WAIT;
                ST_DIV_WAIT: if (div_done) state <= ST_REFINE;
                ST_REFINE: begin
                    if (converged) begin
                        state <= ST_WRITE;
                    end else begin
                        x_r     <= x_next;
                        first_r <= 1'b0;
                        state   <= ST_DIV_GO;
                    end
                end
                ST_WRITE:    state <= ST_ADVANCE;
                ST_ADVANCE: begin
                    remain_r <= remain_r - DATA_W'(1);
                    idx_r    <= idx_r + AIDX_W'(1);
                    state    <= ST_CNT_TEST;
                end
                ST_FINISH:   state <= ST_FINISH;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    AST_READ_PAIR: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_en) |=> (rd_en && $stable(bus_addr)));            // R2
    AST_READ_LEN: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |=> !rd_en);                       // R2
    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);                                         // R9
    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));                                        // R8
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);                                          // R7
    AST_SMALL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (s_r <= ONE_FX)) |-> (x_r == s_r));              // R4
    AST_ROOT_BELOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (s_r > ONE_FX)) |-> (x_r < s_r));                // R5
    AST_REFINE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REFINE) |-> !div_busy);                       // R6

endmodule

// File: tb/heron_sqrt_engine_tb.sv
`timescale 1ns/1ps
module heron_sqrt_engine_tb;

    localparam logic [31:0] SENT = 32'hA5A5_5A5A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    wire  [31:0] bus_data;
    logic [31:0] bus_addr;
    logic        rd_en;
    logic        wr_en;
    logic        ready;

    logic [31:0] mem  [0:1023];
    int          wcnt [0:1023];
    logic [31:0] ops  [0:127];
    logic        tb_we = 1'b0;
    logic        tb_clr = 1'b0;
    logic [9:0]  tb_addr = '0;
    logic [31:0] tb_data = '0;
    logic        prev_wr = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    heron_sqrt_engine u_dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .bus_data (bus_data),
        .bus_addr (bus_addr),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .ready    (ready)
    );

    // RAM model: combinational read, write on the clock edge.
    assign bus_data = rd_en ? mem[bus_addr[9:0]] : 32'bz;

    always @(posedge clk) begin
        if (tb_clr) begin
            for (int i = 0; i < 1024; i++) wcnt[i] <= 0;
        end else if (wr_en) begin
            mem[bus_addr[9:0]]  <= bus_data;
            wcnt[bus_addr[9:0]] <= wcnt[bus_addr[9:0]] + 1;
        end
        if (tb_we) mem[tb_addr] <= tb_data;
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Bus protocol monitor (R8, R9)
    always @(negedge clk) begin
        if (rst) begin
            prev_wr = 1'b0;
        end else begin
            if (rd_en || wr_en) begin
                chk(bus_addr[31:10] == '0, "R8 addr high", bus_addr, {22'b0, bus_addr[9:0]});
                chk(!(rd_en && wr_en), "R8 excl", {30'b0, rd_en, wr_en}, 32'h0);
            end
            if (prev_wr) chk(!wr_en, "R9 single write", {31'b0, wr_en}, 32'h0);
            prev_wr = wr_en;
        end
    end

    // Expected root from the update rule of R5 with exact quotient of R6.
    function automatic logic [31:0] root_model(input logic [31:0] s);
        logic [63:0] x, q, xn;
        bit          first;
        if (s <= 32'h100) return s;
        x     = {32'b0, s} >> 1;
        first = 1'b1;
        for (int k = 0; k < 400; k++) begin
            q  = ({32'b0, s} << 8) / x;
            xn = ((x + q) >> 1) & 64'hFFFF_FFFF;
            if (!first && (x <= xn)) return x[31:0];
            x     = xn;
            first = 1'b0;
        end
        return x[31:0];
    endfunction

    task automatic run_job(input int n, input bit poke, input string big_tag);
        int cyc;
        @(negedge clk);
        rst    = 1'b1;
        tb_clr = 1'b1;
        @(negedge clk);
        tb_clr = 1'b0;
        for (int i = 0; i <= n + 1; i++) begin
            tb_we   = 1'b1;
            tb_addr = 10'(i);
            tb_data = (i == 0) ? 32'(n) : ((i == n + 1) ? SENT : ops[i-1]);
            @(negedge clk);
        end
        tb_we = 1'b0;
        chk(!ready && !rd_en && !wr_en, "R1 in reset", {29'b0, ready, rd_en, wr_en}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!ready && !rd_en && !wr_en, "R1 idle", {29'b0, ready, rd_en, wr_en}, 32'h0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(rd_en && bus_addr == 32'h0, "R2 count address", bus_addr, 32'h0);
        @(negedge clk);
        chk(rd_en && bus_addr == 32'h0, "R2 count capture", {31'b0, rd_en}, 32'h1);
        @(negedge clk);
        chk(!rd_en, "R2 read ends", {31'b0, rd_en}, 32'h0);
        if (n == 0) begin
            chk(!ready, "R7 empty early", {31'b0, ready}, 32'h0);
            @(negedge clk);
            chk(ready, "R7 empty ready", {31'b0, ready}, 32'h1);
        end
        if (poke) begin
            repeat (10) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!ready && cyc < 100000) begin
            @(negedge clk);
            cyc++;
        end
        chk(ready, "R7 ready reached", {31'b0, ready}, 32'h1);
        for (int i = 1; i <= n; i++) begin
            logic [31:0] e;
            e = root_model(ops[i-1]);
            chk(mem[i] == e, (ops[i-1] <= 32'h100) ? "R4 small operand" : big_tag, mem[i], e);
            chk(wcnt[i] == 1, "R3 one write", 32'(wcnt[i]), 32'h1);
        end
        chk(wcnt[0] == 0 && mem[0] == 32'(n), "R3 count word kept", mem[0], 32'(n));
        chk(wcnt[n+1] == 0 && mem[n+1] == SENT, "R3 neighbour kept", mem[n+1], SENT);
        // start while ready is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(ready && !rd_en && !wr_en, "R7 start ignored", {29'b0, ready, rd_en, wr_en}, 32'h4);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);

        // Job 1: the worked examples
        ops[0] = 32'h400; ops[1] = 32'h1000; ops[2] = 32'h0; ops[3] = 32'h100;
        run_job(4, 1'b0, "R5 value");
        chk(mem[1] == 32'h200, "R5 root of 4.0", mem[1], 32'h200);
        chk(mem[2] == 32'h400, "R5 root of 16.0", mem[2], 32'h400);
        chk(mem[3] == 32'h0, "R4 zero kept", mem[3], 32'h0);
        chk(mem[4] == 32'h100, "R4 one kept", mem[4], 32'h100);

        // Job 2: empty array
        run_job(0, 1'b0, "R5 value");

        // Job 3: boundary operands, start poked mid-run
        ops[0] = 32'hFF;       ops[1] = 32'h100;      ops[2] = 32'h101;
        ops[3] = 32'hFFFF_FFFF; ops[4] = 32'h8000_0000; ops[5] = 32'h900;
        ops[6] = 32'h200;      ops[7] = 32'h1;
        run_job(8, 1'b1, "R6 quotient path");
        chk(mem[6] == 32'h300, "R5 root of 9.0", mem[6], 32'h300);

        // Job 4: sweep across the 1.0 boundary
        for (int i = 0; i < 61; i++) ops[i] = 32'(240 + i);
        run_job(61, 1'b0, "R5 near one");

        // Job 5: spread of larger operands
        for (int i = 0; i < 64; i++) ops[i] = 32'(i * i * i * 97 + i * 13 + 200);
        run_job(64, 1'b0, "R5 sweep");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule